// File: doc/BRIEF.md
# Transaction latency credit monitor

This block watches transactions moving through a memory controller pipeline and works out how long each one took once the cycles it spent stalled are taken off. A transaction opens with a start event that carries a tag, a type and a path mask. It closes with an end event on the same tag. While it is open, its own entry in a tag-indexed table counts flight time. The same entry also collects a stall credit from the per-cycle stall sources, but only from the sources that lie on that transaction's path.

When a transaction ends, the block subtracts the credit from the flight time. It reports the result with the transaction type and compares it with a programmable limit for that type. The violation flag rises when the limit is exceeded. The block also keeps a running minimum and maximum of the adjusted latency for each type. The limits and the statistics sit behind a small register port, and a clear input restarts the statistics. Verification environments and on-chip monitors use the block to catch performance regressions. Without the credit, congestion would hide them, because on an uncontended path the adjusted latency should stay near the pipeline depth.

Top module: `lat_credit_mon`

## Requirements
- R1: A start event on `start_tag` opens that table entry with its type (0 program read, 1 data read, 2 coherence, 3 DMA) and path mask. An end event on an open tag produces a one-cycle `done_vld` in the cycle after the end, with `done_type` equal to the type given at start.
- R2: Flight time is the number of clock cycles from the start cycle to the end cycle. An end one cycle after its start has a flight time of 1.
- R3: In each cycle after the start cycle, up to and including the end cycle, the entry's credit grows by the number of set bits in `stall_src & path`. Stalls in the start cycle itself are not counted.
- R4: `done_adj` equals the flight time minus the credit, floored at 0.
- R5: A stall source whose bit is clear in a transaction's path mask never changes that transaction's adjusted latency.
- R6: Up to NUM_TAGS transactions can be open at once, and each is timed and credited independently of the others.
- R7: Each type has a limit that resets to PIPE_DEPTH+LIM_SLACK (8 by default). `viol` pulses together with `done_vld` only when `done_adj` is strictly greater than that type's limit.
- R8: A write with `reg_addr` = {type, 2'b00} sets that type's limit. The new value reads back at the same address and applies to ends in later cycles.
- R9: Reads at {type, 2'b01} and {type, 2'b10} return that type's minimum and maximum adjusted latency. After reset these are 16'hFFFF and 0. Field 2'b11 reads 0.
- R10: `stat_clr` returns every type's minimum to 16'hFFFF and maximum to 0. The clear wins over an update in the same cycle.
- R11: An end event on a tag that is not open is ignored: no `done_vld`, and the statistics do not change.
- R12: Flight and credit counters are 16 bits wide and saturate at 16'hFFFF.
- R13: A start and an end on the same open tag in the same cycle complete the old transaction and open a fresh one, whose counts start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_vld | input | 1 | Transaction start event |
| start_tag | input | TAG_W | Tag of the starting transaction |
| start_type | input | 2 | Type of the starting transaction |
| start_path | input | SRC_N | Stall sources on this transaction's path |
| end_vld | input | 1 | Transaction end event |
| end_tag | input | TAG_W | Tag of the ending transaction |
| stall_src | input | SRC_N | Per-cycle stall indicators from stages and arbiters |
| stat_clr | input | 1 | Clear minimum and maximum statistics |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address {type, field} |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| done_vld | output | 1 | Result valid, one cycle after the end |
| done_type | output | 2 | Type of the completed transaction |
| done_adj | output | 16 | Adjusted latency of the completed transaction |
| viol | output | 1 | Adjusted latency above the type limit |

## Verification
The bench targets the off-by-one edges of the timing window. A design that counted the stall in the start cycle, or dropped the one in the end cycle, would report latencies off by the source count. A latency equal to the limit must pass and one above it must fail; an inclusive comparison would flag the first as well. The bench also retires one tag and restarts it in the same cycle, and a design that let the new start win would lose the old result or carry stale counts into the new transaction. Further stimuli cover credit that exceeds flight time, which must floor at zero rather than wrap; a 70000-cycle transaction, which must stick at 16'hFFFF; an end on an idle tag, which must stay silent; and a clear that arrives together with an update.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

    localparam int CNT_W     = 16;
    localparam int TYPE_W    = 2;
    localparam int NUM_TYPES = 1 << TYPE_W;
    localparam int SRC_N     = 4;
    localparam int FLD_W     = 2;
    localparam int ADDR_W    = TYPE_W + FLD_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [TYPE_W-1:0] {
        TT_PROG = 2'd0,
        TT_DATA = 2'd1,
        TT_COH  = 2'd2,
        TT_DMA  = 2'd3
    } txn_type_e;

    typedef enum logic [FLD_W-1:0] {
        FLD_LIM = 2'd0,
        FLD_MIN = 2'd1,
        FLD_MAX = 2'd2,
        FLD_NUL = 2'd3
    } reg_fld_e;

    typedef struct packed {
        logic             live;
        txn_type_e        ttype;
        logic [SRC_N-1:0] path;
        cnt_t             flight;
        cnt_t             credit;
    } slot_s;

    typedef struct packed {
        logic      vld;
        txn_type_e ttype;
        cnt_t      adj;
        logic      over;
    } result_s;

    function automatic cnt_t sat_add(cnt_t a, cnt_t b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CNT_W] ? '1 : s[CNT_W-1:0];
    endfunction

    function automatic cnt_t bit_count(logic [SRC_N-1:0] v);
        cnt_t n;
        n = '0;
        for (int i = 0; i < SRC_N; i++) n = n + cnt_t'(v[i]);
        return n;
    endfunction

    function automatic cnt_t floor_sub(cnt_t a, cnt_t b);
        return (a > b) ? (a - b) : '0;
    endfunction

endpackage

// File: rtl/lcm_slot.sv
module lcm_slot
    import lcm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc,
    input  logic [TYPE_W-1:0]   alloc_type,
    input  logic [SRC_N-1:0]    alloc_path,
    input  logic                retire,
    input  logic [SRC_N-1:0]    stall,
    output slot_s               st,
    output cnt_t                fin_flight,
    output cnt_t                fin_credit
);

    always_comb begin
        fin_flight = sat_add(st.flight, cnt_t'(1));
        fin_credit = sat_add(st.credit, bit_count(stall & st.path));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (alloc) begin
            st.live   <= 1'b1;
            st.ttype  <= txn_type_e'(alloc_type);
            st.path   <= alloc_path;
            st.flight <= '0;
            st.credit <= '0;
        end else if (retire) begin
            st.live <= 1'b0;
        end else if (st.live) begin
            st.flight <= fin_flight;
            st.credit <= fin_credit;
        end
    end

endmodule

// File: rtl/lcm_type_stat.sv
module lcm_type_stat
    import lcm_pkg::*;
#(
    parameter int DEF_LIM = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic lim_wr,
    input  cnt_t lim_wdata,
    input  logic upd,
    input  cnt_t adj,
    output cnt_t lim_q,
    output cnt_t min_q,
    output cnt_t max_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= cnt_t'(DEF_LIM);
            min_q <= '1;
            max_q <= '0;
        end else begin
            if (lim_wr) lim_q <= lim_wdata;
            if (clr) begin
                min_q <= '1;
                max_q <= '0;
            end else if (upd) begin
                if (adj < min_q) min_q <= adj;
                if (adj > max_q) max_q <= adj;
            end
        end
    end

endmodule

// File: rtl/lat_credit_mon.sv
module lat_credit_mon
    import lcm_pkg::*;
#(
    parameter int NUM_TAGS   = 8,
    parameter int PIPE_DEPTH = 6,
    parameter int LIM_SLACK  = 2,
    localparam int TAG_W     = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_vld,
    input  logic [TAG_W-1:0]      start_tag,
    input  logic [TYPE_W-1:0]     start_type,
    input  logic [SRC_N-1:0]      start_path,
    input  logic                  end_vld,
    input  logic [TAG_W-1:0]      end_tag,
    input  logic [SRC_N-1:0]      stall_src,
    input  logic                  stat_clr,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [CNT_W-1:0]      reg_wdata,
    output logic [CNT_W-1:0]      reg_rdata,
    output logic                  done_vld,
    output logic [TYPE_W-1:0]     done_type,
    output logic [CNT_W-1:0]      done_adj,
    output logic                  viol
);

    localparam int DEF_LIM = PIPE_DEPTH + LIM_SLACK;

    slot_s   st     [NUM_TAGS];
    cnt_t    fin_f  [NUM_TAGS];
    cnt_t    fin_c  [NUM_TAGS];
    logic [NUM_TAGS-1:0] live_vec;

    cnt_t    lim_arr [NUM_TYPES];
    cnt_t    min_arr [NUM_TYPES];
    cnt_t    max_arr [NUM_TYPES];
    cnt_t [NUM_TYPES-1:0] min_pk;
    cnt_t [NUM_TYPES-1:0] max_pk;

    slot_s   end_st;
    cnt_t    end_f;
    cnt_t    end_c;
    logic    end_hit;
    cnt_t    adj_c;
    result_s res_q;

    logic [TYPE_W-1:0] rd_sel;
    reg_fld_e          rd_fld;

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
        lcm_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .alloc      (start_vld && (start_tag == TAG_W'(g))),
            .alloc_type (start_type),
            .alloc_path (start_path),
            .retire     (end_vld && (end_tag == TAG_W'(g))),
            .stall      (stall_src),
            .st         (st[g]),
            .fin_flight (fin_f[g]),
            .fin_credit (fin_c[g])
        );
        assign live_vec[g] = st[g].live;
    end

    always_comb begin
        end_st  = st[end_tag];
        end_f   = fin_f[end_tag];
        end_c   = fin_c[end_tag];
        end_hit = end_vld && end_st.live;
        adj_c   = floor_sub(end_f, end_c);
    end

    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
        lcm_type_stat #(.DEF_LIM(DEF_LIM)) u_stat (
            .clk       (clk),
            .rst       (rst),
            .clr       (stat_clr),
            .lim_wr    (reg_wr && (reg_addr[ADDR_W-1:FLD_W] == TYPE_W'(t))
                               && (reg_fld_e'(reg_addr[FLD_W-1:0]) == FLD_LIM)),
            .lim_wdata (reg_wdata),
            .upd       (end_hit && (end_st.ttype == txn_type_e'(t))),
            .adj       (adj_c),
            .lim_q     (lim_arr[t]),
            .min_q     (min_arr[t]),
            .max_q     (max_arr[t])
        );
        assign min_pk[t] = min_arr[t];
        assign max_pk[t] = max_arr[t];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld   <= end_hit;
            res_q.ttype <= end_st.ttype;
            res_q.adj   <= adj_c;
            res_q.over  <= end_hit && (adj_c > lim_arr[end_st.ttype]);
        end
    end

    always_comb begin
        rd_sel = reg_addr[ADDR_W-1:FLD_W];
        rd_fld = reg_fld_e'(reg_addr[FLD_W-1:0]);
        case (rd_fld)
            FLD_LIM: reg_rdata = lim_arr[rd_sel];
            FLD_MIN: reg_rdata = min_arr[rd_sel];
            FLD_MAX: reg_rdata = max_arr[rd_sel];
            default: reg_rdata = '0;
        endcase
    end

    assign done_vld  = res_q.vld;
    assign done_type = res_q.ttype;
    assign done_adj  = res_q.adj;
    assign viol      = res_q.over;

endmodule

// File: rtl/lat_credit_mon_chk.sv
module lat_credit_mon_chk
    import lcm_pkg::*;
#(
    parameter int NUM_TAGS = 8,
    parameter int TAG_W    = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start_vld,
    input logic [TAG_W-1:0]      start_tag,
    input logic                  end_vld,
    input logic [TAG_W-1:0]      end_tag,
    input logic                  stat_clr,
    input logic                  done_vld,
    input logic                  viol,
    input logic [NUM_TAGS-1:0]   live_vec,
    input cnt_t [NUM_TYPES-1:0]  min_pk,
    input cnt_t [NUM_TYPES-1:0]  max_pk
);

    // R7
    viol_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        viol |-> done_vld);

    // R1
    done_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_vld |-> $past(end_vld));

    // R11
    stray_end_chk: assert property (@(posedge clk) disable iff (rst)
        (end_vld && !live_vec[end_tag]) |=> !done_vld);

    // R10
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        stat_clr |=> ((max_pk == '0) && (min_pk == '1)));

    // R13
    retire_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (start_vld && end_vld && (start_tag == end_tag) && live_vec[end_tag])
        |=> (done_vld && live_vec[$past(end_tag)]));

endmodule

bind lat_credit_mon lat_credit_mon_chk #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_vld (start_vld),
    .start_tag (start_tag),
    .end_vld   (end_vld),
    .end_tag   (end_tag),
    .stat_clr  (stat_clr),
    .done_vld  (done_vld),
    .viol      (viol),
    .live_vec  (live_vec),
    .min_pk    (min_pk),
    .max_pk    (max_pk)
);

// File: tb/lat_credit_mon_tb_top.sv
`timescale 1ns/1ps
module lat_credit_mon_tb_top;

    localparam int NT   = 8;
    localparam int SATV = 65535;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_vld = 0;
    logic [2:0]  start_tag = 0;
    logic [1:0]  start_type = 0;
    logic [3:0]  start_path = 0;
    logic        end_vld = 0;
    logic [2:0]  end_tag = 0;
    logic [3:0]  stall_src = 0;
    logic        stat_clr = 0;
    logic        reg_wr = 0;
    logic [3:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        done_vld;
    logic [1:0]  done_type;
    logic [15:0] done_adj;
    logic        viol;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int    ttype;
        int    adj;
        bit    over;
        string req;
    } exp_t;
    exp_t sbq[$];

    bit m_live [NT];
    int m_type [NT];
    int m_path [NT];
    int m_fl   [NT];
    int m_cr   [NT];
    int m_lim  [4];
    int m_min  [4];
    int m_max  [4];
    string cur_req = "R1";

    lat_credit_mon dut_i (
        .clk(clk), .rst(rst),
        .start_vld(start_vld), .start_tag(start_tag), .start_type(start_type),
        .start_path(start_path), .end_vld(end_vld), .end_tag(end_tag),
        .stall_src(stall_src), .stat_clr(stat_clr), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done_vld(done_vld), .done_type(done_type), .done_adj(done_adj), .viol(viol)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > SATV) ? SATV : v;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done_vld) begin
            if (sbq.size() == 0) begin
                chk(0, cur_req, "unexpected done_vld", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(int'(done_type) == e.ttype, e.req, "done_type", int'(done_type), e.ttype);
                chk(int'(done_adj) == e.adj, e.req, "done_adj", int'(done_adj), e.adj);
                chk(viol == e.over, e.req, "viol", int'(viol), int'(e.over));
            end
        end
    end

    // One clock cycle of stimulus plus reference model update
    task automatic cyc(input bit sv, input int st, input int sty, input int sp,
                       input bit ev, input int et, input int stall);
        start_vld  = sv;  start_tag = 3'(st); start_type = 2'(sty); start_path = 4'(sp);
        end_vld    = ev;  end_tag = 3'(et);   stall_src = 4'(stall);
        if (ev && m_live[et]) begin
            exp_t e;
            int f, c, a;
            f = sat(m_fl[et] + 1);
            c = sat(m_cr[et] + $countones(stall & m_path[et]));
            a = (f > c) ? f - c : 0;
            e.ttype = m_type[et]; e.adj = a; e.over = (a > m_lim[m_type[et]]); e.req = cur_req;
            sbq.push_back(e);
            if (!stat_clr) begin
                if (a < m_min[m_type[et]]) m_min[m_type[et]] = a;
                if (a > m_max[m_type[et]]) m_max[m_type[et]] = a;
            end
        end
        for (int i = 0; i < NT; i++) begin
            if (m_live[i] && !(ev && et == i)) begin
                m_fl[i] = sat(m_fl[i] + 1);
                m_cr[i] = sat(m_cr[i] + $countones(stall & m_path[i]));
            end
        end
        if (ev) m_live[et] = 0;
        if (sv) begin
            m_live[st] = 1; m_type[st] = sty; m_path[st] = sp; m_fl[st] = 0; m_cr[st] = 0;
        end
        if (stat_clr) begin
            for (int t = 0; t < 4; t++) begin m_min[t] = SATV; m_max[t] = 0; end
        end
        if (reg_wr && reg_addr[1:0] == 2'd0) m_lim[reg_addr[3:2]] = int'(reg_wdata);
        @(posedge clk); #1;
        start_vld = 0; end_vld = 0; stall_src = 0; stat_clr = 0; reg_wr = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rd(input int addr, input int exp, input string req);
        reg_addr = 4'(addr);
        #1;
        chk(int'(reg_rdata) == exp, req, $sformatf("reg_rdata@%0d", addr), int'(reg_rdata), exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog", "run timed out", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 4; t++) begin m_lim[t] = 8; m_min[t] = SATV; m_max[t] = 0; end
        for (int i = 0; i < NT; i++) m_live[i] = 0;
        repeat (3) @(posedge clk); #1;
        rst = 0;
        @(posedge clk); #1;

        // Reset state: R7 default limit, R9 stats, field 3 reads zero
        chk(done_vld == 0, "R1", "done_vld after reset", int'(done_vld), 0);
        for (int t = 0; t < 4; t++) rd(t*4 + 0, 8, "R7");
        rd(1, SATV, "R9");
        rd(2, 0, "R9");
        rd(3, 0, "R9");

        // R1 R2: plain transaction, flight 6, no stalls
        cur_req = "R2";
        cyc(1, 1, 0, 0, 0, 0, 0);
        idle(5);
        cyc(0, 0, 0, 0, 1, 1, 0);
        idle(2);

        // R3: start-cycle stall ignored, end-cycle stall counted
        cur_req = "R3";
        cyc(1, 2, 1, 4'b0011, 0, 0, 4'b0011);
        cyc(0, 0, 0, 0, 0, 0, 4'b0001);
        idle(6);
        cyc(0, 0, 0, 0, 1, 2, 4'b0010);
        idle(2);

        // R5 R4: off-path sources ignored; credit above flight floors at 0
        cur_req = "R4";
        cyc(1, 2, 1, 4'b0011, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, 4'b0011);
        for (int i = 0; i < 2; i++) cyc(0, 0, 0, 0, 0, 0, 4'b1100);
        cyc(0, 0, 0, 0, 1, 2, 4'b0001);
        idle(2);
        cur_req = "R5";
        cyc(1, 3, 2, 4'b0100, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 0, 4'b1011);
        cyc(0, 0, 0, 0, 1, 3, 4'b1011);
        idle(2);

        // R7: equal to limit passes, one above violates
        cur_req = "R7";
        cyc(1, 3, 2, 0, 0, 0, 0);
        idle(7);
        cyc(0, 0, 0, 0, 1, 3, 0);
        cyc(1, 3, 2, 0, 0, 0, 0);
        idle(8);
        cyc(0, 0, 0, 0, 1, 3, 0);
        idle(2);

        // R8: raise limit of type 2, read back, 12-cycle run passes
        cur_req = "R8";
        reg_wr = 1; reg_addr = 4'b1000; reg_wdata = 16'd20;
        cyc(0, 0, 0, 0, 0, 0, 0);
        rd(8, 20, "R8");
        cyc(1, 4, 2, 0, 0, 0, 0);
        idle(11);
        cyc(0, 0, 0, 0, 1, 4, 0);
        idle(2);

        // R6: three overlapping transactions with different paths
        cur_req = "R6";
        cyc(1, 4, 0, 4'b0001, 0, 0, 0);
        cyc(1, 5, 1, 4'b0010, 0, 0, 4'b0001);
        cyc(1, 6, 2, 4'b0110, 0, 0, 4'b0011);
        cyc(0, 0, 0, 0, 0, 0, 4'b0111);
        cyc(0, 0, 0, 0, 1, 5, 4'b0010);
        cyc(0, 0, 0, 0, 0, 0, 4'b0101);
        cyc(0, 0, 0, 0, 1, 4, 4'b0001);
        idle(9);
        cyc(0, 0, 0, 0, 1, 6, 4'b0100);
        idle(2);

        // R11: end on an idle tag
        cur_req = "R11";
        cyc(0, 0, 0, 0, 1, 7, 0);
        chk(done_vld == 0, "R11", "done_vld on stray end", int'(done_vld), 0);
        idle(1);
        rd(13, m_min[3], "R11");

        // R13: same-cycle retire and restart on tag 1
        cur_req = "R13";
        cyc(1, 1, 0, 4'b1000, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 4'b1000);
        idle(2);
        cyc(1, 1, 3, 0, 1, 1, 4'b1000);
        idle(3);
        cyc(0, 0, 0, 0, 1, 1, 4'b1000);
        idle(2);

        // R9: statistics read back
        for (int t = 0; t < 4; t++) begin
            rd(t*4 + 1, m_min[t], "R9");
            rd(t*4 + 2, m_max[t], "R9");
        end

        // R10: clear wins over a same-cycle update
        cur_req = "R10";
        cyc(1, 0, 0, 0, 0, 0, 0);
        idle(3);
        stat_clr = 1;
        cyc(0, 0, 0, 0, 1, 0, 0);
        idle(1);
        rd(1, SATV, "R10");
        rd(2, 0, "R10");
        rd(10, 0, "R10");

        // R12: long transaction saturates
        cur_req = "R12";
        cyc(1, 0, 3, 0, 0, 0, 0);
        idle(70000);
        cyc(0, 0, 0, 0, 1, 0, 0);
        idle(2);
        rd(14, SATV, "R12");

        chk(sbq.size() == 0, "R1", "pending results", sbq.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule